// File: doc/BRIEF.md
# Transmit End-of-Interrupt Command Handler

This block takes the host write that closes a transmit interrupt service. The host writes one command byte to a fixed byte address, and that write ends the current interrupt. Every write removes one entry from a small stack of saved interrupt contexts. The same byte also carries commands. One bit discards the current transmit buffer in DMA operation, and it can also mark the following buffer for discard. Another bit marks the end of a synchronous frame. A third bit reports that no data reached the transmit FIFO. Two more bits copy a separate timer-value byte into one of two general countdown timers.

Each timer counts down once for every prescaler tick. When a loaded timer reaches zero, the block raises a timer interrupt request. That request stays high until the host clears it. The command results appear on the outputs as single-cycle strobes one clock after the write. The stack depth and the stack entries are visible on the outputs, so the interrupt logic around the block can use them.

Top module: `txEoiCmd`

## Requirements
- R1: After reset, every strobe output is 0. `tmrIrq`, `popErr`, `rsvdErr`, `ctxLevel` and `ctxTop` are also 0.
- R2: The command register sits at address `BASE_ADDR` when `altOrder`=0 and at `BASE_ADDR+1` when `altOrder`=1. A write to the active address drives `eoiPulse` high for exactly the one cycle after the write. A write to any other address has no effect on any output.
- R3: `ctxPush` stores `ctxIn` on top of the stack when the stack is not full, and is ignored when it is full. A write that ends an interrupt lowers `ctxLevel` by one, and `ctxTop` then shows the entry below. A push in the same cycle as such a write is dropped.
- R4: A write that ends an interrupt while `ctxLevel` is 0 leaves the level at 0 and sets the sticky `popErr` flag.
- R5: Command bit 7 set with `dmaMode`=1 drives `termBufPulse`. With `dmaMode`=0 it does not.
- R6: Command bit 7 set with `dmaMode`=1 and `eobIntr`=1 also drives `termNextPulse`, which never fires without `termBufPulse`.
- R7: Command bit 6 set with `syncMode`=1 drives `frameEndPulse`. With `syncMode`=0 it does not.
- R8: Command bit 3 set drives `noXferPulse`, whatever the mode inputs are.
- R9: When `syncMode`=1, command bit 5 loads timer 2 with `timerVal`. Command bit 4 loads timer 1 with `timerVal` in its high byte and zero in its low byte. With `syncMode`=0 neither timer is loaded. Each `tick` lowers a nonzero timer by one. The tick that brings a timer to zero sets `tmrIrq` on the same clock edge.
- R10: Loading a timer with zero never raises `tmrIrq`.
- R11: `tmrIrq` stays high until `tmrIrqClr` is asserted. If a timer reaches zero in the same cycle as a clear, the timer event wins.
- R12: Command bits 2 to 0 must be zero. If any of them is nonzero, the sticky `rsvdErr` flag is set, and all the other bits of the write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | 8 | Host write data (command byte) |
| altOrder | input | 1 | Byte-ordering mode; selects which of the two adjacent addresses is active |
| dmaMode | input | 1 | Transmit data moves by DMA |
| syncMode | input | 1 | Channel runs a synchronous protocol |
| eobIntr | input | 1 | The interrupt in service is a transmit end-of-buffer interrupt |
| ctxPush | input | 1 | Push a context onto the stack |
| ctxIn | input | CTX_W | Context to push |
| timerVal | input | 8 | Timer-value byte |
| tick | input | 1 | Prescaler tick; one timer decrement |
| tmrIrqClr | input | 1 | Clears the timer interrupt request |
| eoiPulse | output | 1 | End-of-interrupt strobe |
| termBufPulse | output | 1 | Discard the current buffer |
| termNextPulse | output | 1 | Discard the next buffer as well |
| frameEndPulse | output | 1 | Frame or block complete |
| noXferPulse | output | 1 | No data was moved in this service |
| tmrIrq | output | 1 | Modem/timer group interrupt request |
| ctxTop | output | CTX_W | Entry on top of the stack (0 when the stack is empty) |
| ctxLevel | output | LVL_W | Number of stacked contexts |
| popErr | output | 1 | Sticky flag: a pop hit an empty stack |
| rsvdErr | output | 1 | Sticky flag: a reserved bit was written as 1 |

## Verification
The bench uses the default parameters. A stack depth of 4 lets a few pushes reach the full and empty edges of the stack. An 8-bit timer 2 lets short loads expire after a handful of ticks. A 16-bit timer 1 loaded with 1 expires after exactly 256 ticks, so the low-byte clearing is checked at its true boundary. The base address 0x85 together with `altOrder` lets both byte-ordering modes and the inactive neighbour address be tested.

// File: rtl/txeoi_pkg.sv
package txeoi_pkg;
  localparam int BIT_TERM   = 7;
  localparam int BIT_FRAME  = 6;
  localparam int BIT_LDT2   = 5;
  localparam int BIT_LDT1   = 4;
  localparam int BIT_NOXFER = 3;
  localparam int RSVD_W     = 3;

  typedef struct packed {
    logic eoi;
    logic termCur;
    logic termNext;
    logic frameEnd;
    logic noXfer;
    logic ld1;
    logic ld2;
    logic rsvd;
  } strobe_t;
endpackage

// File: rtl/txeoi_ctrl.sv
module txeoi_ctrl
  import txeoi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h85
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              altOrder,
  input  logic              dmaMode,
  input  logic              syncMode,
  input  logic              eobIntr,
  output strobe_t           st
);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(BASE_ADDR + 1);

  logic hit;

  always_comb begin
    hit         = wrEn && (wrAddr == (altOrder ? ADDR_B : ADDR_A));
    st          = '0;
    st.eoi      = hit;
    st.termCur  = hit && wrData[BIT_TERM] && dmaMode;
    st.termNext = hit && wrData[BIT_TERM] && dmaMode && eobIntr;
    st.frameEnd = hit && wrData[BIT_FRAME] && syncMode;
    st.noXfer   = hit && wrData[BIT_NOXFER];
    st.ld1      = hit && wrData[BIT_LDT1] && syncMode;
    st.ld2      = hit && wrData[BIT_LDT2] && syncMode;
    st.rsvd     = hit && (wrData[RSVD_W-1:0] != '0);
  end
endmodule

// File: rtl/txeoi_timer.sv
module txeoi_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  input  logic         tick,
  output logic         hitZero
);
  logic [W-1:0] cnt;

  // Expiry is flagged combinationally on the tick that takes the count from 1 to 0.
  // A load in the same cycle wins, so that tick is not counted as an expiry.
  assign hitZero = tick && !ld && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= ldVal;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  a_r9_load_value: assert property (@(posedge clk) disable iff (!rstN)
    ld |=> cnt == $past(ldVal));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !ld) |=> cnt == '0);
endmodule

// File: rtl/txeoi_dpath.sv
module txeoi_dpath
  import txeoi_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CTX_W = 4,
  parameter int T1_W  = 16,
  parameter int T2_W  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic             ctxPush,
  input  logic [CTX_W-1:0] ctxIn,
  input  logic [7:0]       timerVal,
  input  logic             tick,
  input  logic             tmrIrqClr,
  output logic             eoiPulse,
  output logic             termBufPulse,
  output logic             termNextPulse,
  output logic             frameEndPulse,
  output logic             noXferPulse,
  output logic             tmrIrq,
  output logic [CTX_W-1:0] ctxTop,
  output logic [LVL_W-1:0] ctxLevel,
  output logic             popErr,
  output logic             rsvdErr
);
  logic [CTX_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0] topLvl;
  logic             canPush;
  logic             hit1, hit2;

  assign topLvl  = ctxLevel - LVL_W'(1);
  assign canPush = ctxPush && !st.eoi && (ctxLevel != LVL_W'(DEPTH));
  assign ctxTop  = (ctxLevel == '0) ? '0 : mem[topLvl[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (canPush) mem[ctxLevel[IDX_W-1:0]] <= ctxIn;
  end

  // The stack pointer: a pop takes priority over a push in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxLevel <= '0;
      popErr   <= 1'b0;
    end else if (st.eoi) begin
      if (ctxLevel != '0) ctxLevel <= topLvl;
      else                popErr   <= 1'b1;
    end else if (canPush) begin
      ctxLevel <= ctxLevel + LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eoiPulse      <= 1'b0;
      termBufPulse  <= 1'b0;
      termNextPulse <= 1'b0;
      frameEndPulse <= 1'b0;
      noXferPulse   <= 1'b0;
      rsvdErr       <= 1'b0;
    end else begin
      eoiPulse      <= st.eoi;
      termBufPulse  <= st.termCur;
      termNextPulse <= st.termNext;
      frameEndPulse <= st.frameEnd;
      noXferPulse   <= st.noXfer;
      if (st.rsvd) rsvdErr <= 1'b1;
    end
  end

  txeoi_timer #(.W(T1_W)) tmr1_i (
    .clk(clk), .rstN(rstN), .ld(st.ld1),
    .ldVal({timerVal, {(T1_W-8){1'b0}}}), .tick(tick), .hitZero(hit1));

  txeoi_timer #(.W(T2_W)) tmr2_i (
    .clk(clk), .rstN(rstN), .ld(st.ld2),
    .ldVal(T2_W'(timerVal)), .tick(tick), .hitZero(hit2));

  always_ff @(posedge clk) begin
    if (!rstN)                tmrIrq <= 1'b0;
    else if (hit1 || hit2)    tmrIrq <= 1'b1;
    else if (tmrIrqClr)       tmrIrq <= 1'b0;
  end

  a_r3_pop_level: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoi && ctxLevel != '0) |=> ctxLevel == $past(ctxLevel) - LVL_W'(1));
  a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoi && ctxLevel == '0) |=> (popErr && ctxLevel == '0));
  a_r6_next_with_cur: assert property (@(posedge clk) disable iff (!rstN)
    termNextPulse |-> termBufPulse);
  a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (tmrIrq && !tmrIrqClr) |=> tmrIrq);
  a_r2_eoi_single: assert property (@(posedge clk) disable iff (!rstN)
    eoiPulse |-> $past(st.eoi));
endmodule

// File: rtl/txEoiCmd.sv
module txEoiCmd
  import txeoi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h85,
  parameter int DEPTH     = 4,
  parameter int CTX_W     = 4,
  parameter int T1_W      = 16,
  parameter int T2_W      = 8,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              altOrder,
  input  logic              dmaMode,
  input  logic              syncMode,
  input  logic              eobIntr,
  input  logic              ctxPush,
  input  logic [CTX_W-1:0]  ctxIn,
  input  logic [7:0]        timerVal,
  input  logic              tick,
  input  logic              tmrIrqClr,
  output logic              eoiPulse,
  output logic              termBufPulse,
  output logic              termNextPulse,
  output logic              frameEndPulse,
  output logic              noXferPulse,
  output logic              tmrIrq,
  output logic [CTX_W-1:0]  ctxTop,
  output logic [LVL_W-1:0]  ctxLevel,
  output logic              popErr,
  output logic              rsvdErr
);
  strobe_t st;

  txeoi_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .altOrder(altOrder),
    .dmaMode(dmaMode), .syncMode(syncMode), .eobIntr(eobIntr), .st(st));

  txeoi_dpath #(.DEPTH(DEPTH), .CTX_W(CTX_W), .T1_W(T1_W), .T2_W(T2_W)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .ctxPush(ctxPush), .ctxIn(ctxIn),
    .timerVal(timerVal), .tick(tick), .tmrIrqClr(tmrIrqClr),
    .eoiPulse(eoiPulse), .termBufPulse(termBufPulse), .termNextPulse(termNextPulse),
    .frameEndPulse(frameEndPulse), .noXferPulse(noXferPulse), .tmrIrq(tmrIrq),
    .ctxTop(ctxTop), .ctxLevel(ctxLevel), .popErr(popErr), .rsvdErr(rsvdErr));
endmodule

// File: tb/txEoiCmd_tb_top.sv
module txEoiCmd_tb_top;
  localparam int ADDR_W = 8;
  localparam int BASE   = 'h85;
  localparam int DEPTH  = 4;
  localparam int CTX_W  = 4;
  localparam int LVL_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic altOrder = 1'b0, dmaMode = 1'b0, syncMode = 1'b0, eobIntr = 1'b0;
  logic ctxPush = 1'b0;
  logic [CTX_W-1:0] ctxIn = '0;
  logic [7:0] timerVal = '0;
  logic tick = 1'b0, tmrIrqClr = 1'b0;
  logic eoiPulse, termBufPulse, termNextPulse, frameEndPulse, noXferPulse, tmrIrq;
  logic [CTX_W-1:0] ctxTop;
  logic [LVL_W-1:0] ctxLevel;
  logic popErr, rsvdErr;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;
  int expLvl = 0;
  logic expPopErr = 1'b0;
  logic [CTX_W-1:0] expStk [DEPTH];

  always #5 clk = ~clk;

  txEoiCmd dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .altOrder(altOrder), .dmaMode(dmaMode), .syncMode(syncMode), .eobIntr(eobIntr),
    .ctxPush(ctxPush), .ctxIn(ctxIn), .timerVal(timerVal), .tick(tick),
    .tmrIrqClr(tmrIrqClr), .eoiPulse(eoiPulse), .termBufPulse(termBufPulse),
    .termNextPulse(termNextPulse), .frameEndPulse(frameEndPulse),
    .noXferPulse(noXferPulse), .tmrIrq(tmrIrq), .ctxTop(ctxTop),
    .ctxLevel(ctxLevel), .popErr(popErr), .rsvdErr(rsvdErr));

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected strobes {eoi, termBuf, termNext, frameEnd, noXfer}.
  function automatic logic [4:0] expStrobes(input logic [7:0] d, input logic dma,
                                            input logic sy, input logic eob);
    return {1'b1, d[7] & dma, d[7] & dma & eob, d[6] & sy, d[3]};
  endfunction

  function automatic logic [CTX_W-1:0] expTop();
    return (expLvl == 0) ? '0 : expStk[expLvl-1];
  endfunction

  // A write to the active address; the outputs are sampled at the following falling edge.
  task automatic doWrite(input logic [7:0] d);
    wrAddr = altOrder ? ADDR_W'(BASE + 1) : ADDR_W'(BASE);
    wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    if (expLvl > 0) expLvl--; else expPopErr = 1'b1;
  endtask

  task automatic push(input logic [CTX_W-1:0] v);
    ctxIn = v; ctxPush = 1'b1;
    @(negedge clk); ctxPush = 1'b0;
    if (expLvl < DEPTH) begin expStk[expLvl] = v; expLvl++; end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nTests++; nFail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        finishRun();
      end
    end
  end

  initial begin
    logic [4:0] e;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 strobes", {eoiPulse, termBufPulse, termNextPulse, frameEndPulse, noXferPulse}, 0);
    check("R1 flags", {tmrIrq, popErr, rsvdErr}, 0);
    check("R1 level", ctxLevel, 0);
    check("R1 top", ctxTop, 0);

    // R3 push until full, then one push ignored
    push(4'h3); push(4'h9); push(4'hA); push(4'h5);
    check("R3 full level", ctxLevel, 4);
    push(4'hF);
    check("R3 push when full", ctxLevel, 4);
    check("R3 top when full", ctxTop, 4'h5);

    // R2 inactive neighbour address, then the active one in each byte order
    wrAddr = ADDR_W'(BASE + 1); wrData = 8'hC8; wrEn = 1'b1; dmaMode = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    check("R2 wrong addr eoi", eoiPulse, 0);
    check("R2 wrong addr term", termBufPulse, 0);
    check("R2 wrong addr level", ctxLevel, 4);
    doWrite(8'h00);
    check("R2 eoi mode0", eoiPulse, 1);
    check("R3 pop level", ctxLevel, 3);
    check("R3 pop top", ctxTop, 4'hA);
    @(negedge clk);
    check("R2 eoi one cycle", eoiPulse, 0);
    altOrder = 1'b1;
    wrAddr = ADDR_W'(BASE); wrData = 8'h00; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    check("R2 base ignored in mode1", eoiPulse, 0);
    doWrite(8'h00);
    check("R2 eoi mode1", eoiPulse, 1);
    check("R3 top after two pops", ctxTop, 4'h9);
    altOrder = 1'b0;

    // R3 push dropped when it meets a pop
    ctxIn = 4'h7; ctxPush = 1'b1; wrAddr = ADDR_W'(BASE); wrData = 8'h00; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; ctxPush = 1'b0; expLvl--;
    check("R3 push dropped on pop", ctxLevel, 1);
    check("R3 top after drop", ctxTop, 4'h3);

    // R5, R6 terminate buffer
    dmaMode = 1'b1; eobIntr = 1'b0;
    doWrite(8'h80);
    check("R5 term dma", termBufPulse, 1);
    check("R6 next without eob", termNextPulse, 0);
    check("R4 level at empty", ctxLevel, 0);
    eobIntr = 1'b1;
    doWrite(8'h80);
    check("R6 next with eob", termNextPulse, 1);
    check("R4 pop empty err", popErr, 1);
    check("R4 level stays", ctxLevel, 0);
    dmaMode = 1'b0;
    doWrite(8'h80);
    check("R5 term non-dma", termBufPulse, 0);
    check("R6 next non-dma", termNextPulse, 0);
    eobIntr = 1'b0;

    // R7, R8
    syncMode = 1'b1; doWrite(8'h40);
    check("R7 frame sync", frameEndPulse, 1);
    syncMode = 1'b0; doWrite(8'h48);
    check("R7 frame async", frameEndPulse, 0);
    check("R8 noxfer async", noXferPulse, 1);

    // R12 reserved bits: flag set, command still executed
    check("R12 flag clear before", rsvdErr, 0);
    doWrite(8'h0D);
    check("R12 rsvd flag", rsvdErr, 1);
    check("R12 cmd still runs", noXferPulse, 1);

    // R9 timer 2
    syncMode = 1'b1; timerVal = 8'd5; doWrite(8'h20);
    ticks(4);
    check("R9 t2 before zero", tmrIrq, 0);
    ticks(1);
    check("R9 t2 expires", tmrIrq, 1);
    // R11 hold then clear
    repeat (3) @(negedge clk);
    check("R11 irq holds", tmrIrq, 1);
    tmrIrqClr = 1'b1; @(negedge clk); tmrIrqClr = 1'b0;
    check("R11 irq cleared", tmrIrq, 0);

    // R10 load zero
    timerVal = 8'd0; doWrite(8'h30);
    ticks(6);
    check("R10 zero load no irq", tmrIrq, 0);

    // R9 no load outside sync mode
    syncMode = 1'b0; timerVal = 8'd2; doWrite(8'h20);
    ticks(4);
    check("R9 no load async", tmrIrq, 0);

    // R9 timer 1 low byte cleared: load 1 -> 256 ticks
    syncMode = 1'b1; timerVal = 8'd1; doWrite(8'h10);
    ticks(255);
    check("R9 t1 at 255 ticks", tmrIrq, 0);
    ticks(1);
    check("R9 t1 at 256 ticks", tmrIrq, 1);

    // R11 timer event wins over clear
    timerVal = 8'd1; doWrite(8'h20);
    tmrIrqClr = 1'b1; tick = 1'b1; @(negedge clk); tmrIrqClr = 1'b0; tick = 1'b0;
    check("R11 set beats clear", tmrIrq, 1);
    tmrIrqClr = 1'b1; @(negedge clk); tmrIrqClr = 1'b0;

    // Random command bytes against the bench model (R5 to R8, R3, R4)
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 2) == 0) push(CTX_W'($urandom));
      dmaMode  = 1'($urandom);
      syncMode = 1'($urandom);
      eobIntr  = 1'($urandom);
      altOrder = 1'($urandom);
      d = 8'($urandom) & 8'hF8;
      e = expStrobes(d, dmaMode, syncMode, eobIntr);
      doWrite(d);
      check("R5 R6 R7 R8 random strobes",
            {eoiPulse, termBufPulse, termNextPulse, frameEndPulse, noXferPulse}, e);
      check("R3 random level", ctxLevel, expLvl);
      check("R3 random top", ctxTop, expTop());
      check("R4 random popErr", popErr, expPopErr);
    end
    finishRun();
  end
endmodule